// File: doc/BRIEF.md
# Chained Serial DAC Frame Loader

This block is the host-side master for a string of serial DACs wired in a daisy chain, where each device passes its shifted-out data on to the next. Software or an upstream engine first deposits one 16-bit code per channel into a small word bank through a valid/ready write port, addressing each word by its channel index. A start command then runs one complete transfer. The frame line drops, every word is clocked out serially on a generated bit clock, and the frame line returns high. A single active-low update strobe follows automatically, so that all chained converters change their analog outputs at the same moment.

Words go out by descending channel index, each most significant bit first. The word of the device farthest from the host therefore leaves first, and each device ends up holding its own code. Data changes only on rising bit-clock edges, so it is stable at the falling edges where the devices sample it. The channel count, word width, bit-clock half-period and update-strobe width are parameters. The bit-clock half-period and the strobe width are counted in system clock cycles. Busy and a one-cycle done pulse report progress.

Top module: `dac_chain_loader`

## Requirements
- R1: While reset is held and after it is released: frameN, sclk and updateN are 1, busy, done and sdin are 0, and ldReady is 1.
- R2: When ldValid and ldReady are both high at a clock edge, ldData is stored as the word for channel ldIndex. An index of NUM_CH or above changes nothing.
- R3: A start seen while idle drives frameN low on the next cycle. frameN stays low for exactly NUM_CH*WORD_W falling sclk edges, then returns high.
- R4: The serial bit order within a frame is channel NUM_CH-1 down to channel 0, with each word most significant bit first. For four channels the frame is {w3,w2,w1,w0}, read left to right.
- R5: sclk is high whenever frameN is high. During a frame, each sclk high and low phase lasts SCLK_HALF cycles, and the first phase is high. Within a frame, sdin changes only in a cycle where sclk rises.
- R6: updateN stays high while frameN is low. It goes low exactly one cycle after frameN rises and stays low for exactly UPD_CYC cycles.
- R7: done is high for exactly one cycle, the first cycle in which updateN is high again. busy is high from the cycle after start through that done cycle.
- R8: While busy, ldReady is 0, so writes are refused and leave the stored words unchanged. A start while busy does not begin a second frame.
- R9: With CLK_PERIOD_NS as the system clock period, a full sclk period is at least MIN_SCLK_NS and the updateN low pulse is at least MIN_UPD_NS.
- R10: Stored words persist across frames. A new start without new writes sends the same frame again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Word write request |
| ldIndex | input | IDX_W | Channel index of the word being written |
| ldData | input | WORD_W | Channel code to store |
| ldReady | output | 1 | Write accepted when high (idle only) |
| start | input | 1 | Begin a frame and update sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| frameN | output | 1 | Active-low frame sync to the chain |
| sclk | output | 1 | Serial bit clock, idles high |
| sdin | output | 1 | Serial data to the first device |
| updateN | output | 1 | Active-low simultaneous update strobe |

## Verification
The bench builds the block with four 16-bit channels and a 125 MHz system clock. It sets a half-period of 13 cycles and a strobe width of 13 cycles, so the full 5 MHz bit-clock limit and the 100 ns strobe minimum are met with little margin. This puts the 64-pulse four-channel frame and the per-bit phase timing within a few thousand cycles. Several word patterns are sent, including the single top bit, the single bottom bit and all ones. A write and a second start are attempted mid-frame, and a repeated frame is sent without a reload.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_SETTLE,
    ST_UPDATE,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic wrEn;
    logic capture;
    logic shift;
  } dpStrobe_t;

endpackage

// File: rtl/dcl_datapath.sv
module dcl_datapath
  import dcl_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int WORD_W = 16,
  parameter int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [IDX_W-1:0]  ldIndex,
  input  logic [WORD_W-1:0] ldData,
  output logic              sdin
);

  localparam int TOTAL = NUM_CH * WORD_W;

  logic [WORD_W-1:0] wordBank [NUM_CH];
  logic [TOTAL-1:0]  flatWords;
  logic [TOTAL-1:0]  shiftReg;

  // one register per channel, written by index
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordBank[ch] <= '0;
      end else if (stb.wrEn && (32'(ldIndex) == ch)) begin
        wordBank[ch] <= ldData;
      end
    end
    // highest channel lands at the top so it leaves first
    assign flatWords[ch*WORD_W +: WORD_W] = wordBank[ch];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.capture) begin
      shiftReg <= flatWords;
    end else if (stb.shift) begin
      shiftReg <= {shiftReg[TOTAL-2:0], 1'b0};
    end
  end

  assign sdin = shiftReg[TOTAL-1];

  // R3: a frame never loads and advances in the same cycle
  a_r3_capture_shift_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capture, stb.shift}));

  // R8: the bank is never written while a frame is shifting
  a_r8_no_write_while_shifting: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |-> !stb.wrEn);

endmodule

// File: rtl/dcl_control.sv
module dcl_control
  import dcl_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int WORD_W        = 16,
  parameter int SCLK_HALF     = 13,
  parameter int UPD_CYC       = 13,
  parameter int CLK_PERIOD_NS = 8,
  parameter int MIN_SCLK_NS   = 200,
  parameter int MIN_UPD_NS    = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ldValid,
  input  logic      start,
  output dpStrobe_t stb,
  output logic      ldReady,
  output logic      busy,
  output logic      done,
  output logic      frameN,
  output logic      sclk,
  output logic      updateN
);

  localparam int TOTAL = NUM_CH * WORD_W;
  localparam int BIT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam int HC_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int UC_W  = (UPD_CYC > 1) ? $clog2(UPD_CYC) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(TOTAL - 1);
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(SCLK_HALF - 1);
  localparam logic [UC_W-1:0]  UC_LAST  = UC_W'(UPD_CYC - 1);

  seqState_t        state;
  logic [HC_W-1:0]  halfCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [UC_W-1:0]  updCnt;
  logic             phaseLow;
  logic             halfEnd;
  logic             lastBit;

  assign halfEnd = (halfCnt == HC_LAST);
  assign lastBit = (bitCnt == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      bitCnt   <= '0;
      updCnt   <= '0;
      phaseLow <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_FRAME;
            halfCnt  <= '0;
            bitCnt   <= '0;
            phaseLow <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (halfEnd) begin
            halfCnt <= '0;
            if (!phaseLow) begin
              phaseLow <= 1'b1;
            end else begin
              phaseLow <= 1'b0;
              if (lastBit) state <= ST_SETTLE;
              else         bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_SETTLE: begin
          state  <= ST_UPDATE;
          updCnt <= '0;
        end
        ST_UPDATE: begin
          if (updCnt == UC_LAST) state <= ST_DONE;
          else                   updCnt <= updCnt + 1'b1;
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.wrEn    = ldValid && (state == ST_IDLE);
    stb.capture = start && (state == ST_IDLE);
    stb.shift   = (state == ST_FRAME) && phaseLow && halfEnd && !lastBit;
  end

  assign ldReady = (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign frameN  = (state != ST_FRAME);
  assign updateN = (state != ST_UPDATE);
  assign sclk    = !((state == ST_FRAME) && phaseLow);

  // ---- observation counters for the timing-limit properties ----
  logic        sclkQ, updQ, seenFall;
  logic [15:0] fallGap, updLow;
  logic        sclkFall, updRise;

  assign sclkFall = sclkQ && !sclk;
  assign updRise  = !updQ && updateN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ    <= 1'b1;
      updQ     <= 1'b1;
      seenFall <= 1'b0;
      fallGap  <= '0;
      updLow   <= '0;
    end else begin
      sclkQ <= sclk;
      updQ  <= updateN;
      if (sclkFall) begin
        seenFall <= 1'b1;
        fallGap  <= 16'd1;
      end else if (fallGap != 16'hFFFF) begin
        fallGap <= fallGap + 1'b1;
      end
      if (!updateN) updLow <= updLow + 1'b1;
      else          updLow <= '0;
    end
  end

  // R9: falling-edge to falling-edge spacing meets the bit-clock limit
  a_r9_sclk_period: assert property (@(posedge clk) disable iff (!rstN)
    (sclkFall && seenFall) |-> (32'(fallGap) * CLK_PERIOD_NS >= MIN_SCLK_NS));

  // R9: the update strobe is at least the minimum width
  a_r9_update_width: assert property (@(posedge clk) disable iff (!rstN)
    updRise |-> (32'(updLow) * CLK_PERIOD_NS >= MIN_UPD_NS));

  // R5: bit clock parked high outside the frame
  a_r5_sclk_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    frameN |-> sclk);

  // R6: strobe never overlaps the frame, and follows its end by one cycle
  a_r6_update_outside_frame: assert property (@(posedge clk) disable iff (!rstN)
    !updateN |-> frameN);
  a_r6_update_after_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameN) |=> !updateN);

  // R7: done lasts one cycle and comes right after the strobe ends
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r7_done_after_update: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(!updateN));

  // R8: a sequence begins only from a start seen while idle
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start && ldReady));

endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
  import dcl_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int WORD_W        = 16,
  parameter int SCLK_HALF     = 13,
  parameter int UPD_CYC       = 13,
  parameter int CLK_PERIOD_NS = 8,
  parameter int MIN_SCLK_NS   = 200,
  parameter int MIN_UPD_NS    = 100,
  parameter int IDX_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [IDX_W-1:0]  ldIndex,
  input  logic [WORD_W-1:0] ldData,
  output logic              ldReady,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              frameN,
  output logic              sclk,
  output logic              sdin,
  output logic              updateN
);

  dpStrobe_t stb;

  dcl_control #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .SCLK_HALF(SCLK_HALF), .UPD_CYC(UPD_CYC),
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .MIN_SCLK_NS(MIN_SCLK_NS), .MIN_UPD_NS(MIN_UPD_NS)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .start(start), .stb(stb),
    .ldReady(ldReady), .busy(busy), .done(done), .frameN(frameN),
    .sclk(sclk), .updateN(updateN)
  );

  dcl_datapath #(
    .NUM_CH(NUM_CH), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ldIndex(ldIndex), .ldData(ldData), .sdin(sdin)
  );

endmodule

// File: tb/dac_chain_loader_tb_top.sv
module dac_chain_loader_tb_top;

  localparam int NCH   = 4;
  localparam int WW    = 16;
  localparam int HALF  = 13;
  localparam int UPDC  = 13;
  localparam int PERNS = 8;
  localparam int TOTAL = NCH * WW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0;
  logic [1:0] ldIndex = '0;
  logic [WW-1:0] ldData = '0;
  logic start = 1'b0;
  logic ldReady, busy, done, frameN, sclk, sdin, updateN;

  int nChecks = 0;
  int nFails  = 0;
  logic [TOTAL-1:0] expQ[$];
  logic [WW-1:0] model [NCH];

  always #4 clk = ~clk;

  dac_chain_loader #(
    .NUM_CH(NCH), .WORD_W(WW), .SCLK_HALF(HALF), .UPD_CYC(UPDC), .CLK_PERIOD_NS(PERNS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldIndex(ldIndex), .ldData(ldData),
    .ldReady(ldReady), .start(start), .busy(busy), .done(done), .frameN(frameN),
    .sclk(sclk), .sdin(sdin), .updateN(updateN)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  // ---------------- driver ----------------
  task automatic writeWord(input int idx, input logic [WW-1:0] val);
    @(negedge clk);
    ldValid = 1'b1; ldIndex = 2'(idx); ldData = val;
    check(ldReady == 1'b1, "R2", "ldReady when idle", ldReady, 1);
    @(negedge clk);
    ldValid = 1'b0;
    model[idx] = val;
  endtask

  task automatic runFrame();
    logic [TOTAL-1:0] f;
    for (int c = 0; c < NCH; c++) f[c*WW +: WW] = model[c];
    expQ.push_back(f);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(frameN == 1'b0, "R3", "frameN low after start", frameN, 0);
    check(busy == 1'b1, "R7", "busy after start", busy, 1);
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // ---------------- monitor ----------------
  logic prevFrame = 1'b1, prevSclk = 1'b1, prevUpd = 1'b1, prevDone = 1'b0, prevSdin = 1'b0;
  logic [TOTAL-1:0] col = '0;
  int bitCount = 0, runLen = 0, updLen = 0, cyc = 0, riseCyc = -10;

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (!prevFrame) begin
        if (sclk != prevSclk) begin
          check(runLen == HALF, "R5", "sclk phase length", runLen, HALF);
          check(runLen * 2 * PERNS >= 200, "R9", "sclk period ns", runLen * 2 * PERNS, 200);
          runLen = 1;
        end else runLen++;
      end
      if (!frameN && prevFrame) begin
        runLen = 1; bitCount = 0; col = '0;
      end
      if (!frameN && prevSclk && !sclk) begin
        col = {col[TOTAL-2:0], sdin};
        bitCount++;
      end
      if (!frameN && !prevFrame && sdin != prevSdin)
        check(!prevSclk && sclk, "R5", "sdin change only on sclk rise", {prevSclk, sclk}, 2'b01);
      if (frameN) check(sclk == 1'b1, "R5", "sclk idle high", sclk, 1);
      if (!updateN) check(frameN == 1'b1, "R6", "updateN high during frame", frameN, 1);
      if (frameN && !prevFrame) begin
        riseCyc = cyc;
        check(bitCount == TOTAL, "R3", "falling edges per frame", bitCount, TOTAL);
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected frame", 1, 0);
        end else begin
          logic [TOTAL-1:0] e;
          e = expQ.pop_front();
          check(col == e, "R4", "frame bits", col, e);
        end
      end
      if (!updateN && prevUpd) begin
        check(cyc == riseCyc + 1, "R6", "updateN fall cycle", cyc - riseCyc, 1);
        updLen = 1;
      end else if (!updateN) updLen++;
      if (updateN && !prevUpd) begin
        check(updLen == UPDC, "R6", "updateN width", updLen, UPDC);
        check(updLen * PERNS >= 100, "R9", "updateN width ns", updLen * PERNS, 100);
        check(done == 1'b1, "R7", "done with updateN rise", done, 1);
      end
      if (prevDone) check(done == 1'b0, "R7", "done one cycle", done, 0);
      prevFrame = frameN; prevSclk = sclk; prevUpd = updateN;
      prevDone = done; prevSdin = sdin;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    check(frameN && sclk && updateN && !busy && !done && !sdin, "R1", "outputs in reset",
          {frameN, sclk, updateN, busy, done, sdin}, 6'b111000);
    rstN = 1'b1;
    @(negedge clk);
    check(ldReady && frameN && sclk && updateN && !busy && !done, "R1", "outputs after reset",
          {ldReady, frameN, sclk, updateN, busy, done}, 6'b111100);

    // pattern A: single top bit, single bottom bit, all ones
    writeWord(0, 16'hA5C3);
    writeWord(1, 16'h0001);
    writeWord(2, 16'h8000);
    writeWord(3, 16'hFFFF);
    runFrame();
    waitDone();
    check(!busy, "R7", "busy clears after done", busy, 0);

    // pattern B, then interference mid-frame
    writeWord(0, 16'h0000);
    writeWord(1, 16'h1234);
    writeWord(2, 16'h5A5A);
    writeWord(3, 16'h7FFE);
    runFrame();
    repeat (200) @(negedge clk);
    check(ldReady == 1'b0, "R8", "ldReady low while busy", ldReady, 0);
    ldValid = 1'b1; ldIndex = 2'd0; ldData = 16'hDEAD; start = 1'b1;
    @(negedge clk);
    ldValid = 1'b0; start = 1'b0;
    waitDone();
    repeat (60) @(negedge clk);
    check(frameN == 1'b1 && !busy, "R8", "no second frame from busy start",
          {frameN, busy}, 2'b10);

    // R10: repeat without reload; the refused write must not appear
    runFrame();
    waitDone();
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R10", "all expected frames seen", expQ.size(), 0);

    summary();
    $finish;
  end

endmodule